// File: doc/BRIEF.md
# Descriptor Writeback Coalescing Controller

This controller decides when completed descriptors held in an on-chip descriptor cache are copied back to a circular descriptor ring in host memory, and how many go in one transfer. A caller raises a writeback request together with an alignment mask. The controller waits a programmable number of cycles and then sizes the batch. The size is the number of used descriptors, cut short at the end of the ring, or otherwise rounded down to a multiple that the mask allows. It then issues a single DMA write request that carries an address and a byte length.

While a write is outstanding, new requests are not started. A request that is less restrictive (it has a numerically smaller mask) is folded into a follow-up flag. A request that is not less restrictive is discarded. When the DMA engine reports completion, a second programmable delay runs. The controller then pulses a one-cycle "written back" strobe with the descriptor count, so the caller can advance its head index. If a follow-up is pending, a new writeback is armed at once with the stored mask.

Top module: `wb_coalesce_ctrl`

## Requirements
- R1: After reset the controller is idle: dma_req_o and wb_valid_o are low, the stored mask is zero and no follow-up is pending.
- R2: A request taken while idle stores its mask and arms the start timer, and dma_req_o is high in the cycle that begins start_dly_i+1 edges after the accepting edge. A further request before expiry replaces the stored mask but does not restart the timer.
- R3: When head_i+used_i is below ring_len_i and the stored mask is zero, the batch count equals used_i.
- R4: When head_i+used_i is greater than or equal to ring_len_i, the count is ring_len_i-head_i, the mask is not applied, and a follow-up writeback is queued.
- R5: When no wrap occurs and the stored mask is nonzero, the count is used_i AND NOT mask.
- R6: During a one-cycle dma_req_o pulse, dma_addr_o equals base_i+head_i*DESC_BYTES and dma_len_o equals count*DESC_BYTES.
- R7: wb_valid_o pulses for one cycle, done_dly_i+1 edges after the edge that samples dma_done_i high, with wb_count_o equal to the transferred count.
- R8: A request taken during an outstanding writeback whose mask is numerically smaller than the stored one replaces the mask and queues a follow-up. At completion that follow-up is armed through the start delay and uses the stored mask.
- R9: A request taken during an outstanding writeback whose mask is not smaller than the stored one has no effect: no follow-up DMA is issued.
- R10: A computed count of zero issues no DMA and no wb_valid_o, and returns the controller to idle.
- R11: At most one DMA write is outstanding. A new dma_req_o follows only after the wb_valid_o of the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_req_i | input | 1 | Writeback request strobe |
| wb_mask_i | input | IDX_W | Alignment mask carried by the request |
| start_dly_i | input | DLY_W | Cycles to wait before sizing a batch |
| done_dly_i | input | DLY_W | Cycles to wait after DMA completion |
| head_i | input | IDX_W | Current ring head index |
| ring_len_i | input | IDX_W+1 | Ring length in descriptors |
| used_i | input | IDX_W+1 | Used descriptors waiting in the cache |
| base_i | input | ADDR_W | Ring base address |
| dma_req_o | output | 1 | One-cycle DMA write request |
| dma_addr_o | output | ADDR_W | DMA write address |
| dma_len_o | output | IDX_W+1+log2(DESC_BYTES) | DMA write length in bytes |
| dma_done_i | input | 1 | DMA write finished |
| wb_valid_o | output | 1 | One-cycle writeback completion strobe |
| wb_count_o | output | IDX_W+1 | Descriptors written back, valid with wb_valid_o |

## Verification
Several properties are checked on every cycle: both strobes last one cycle, only one DMA write is outstanding, every issued length is nonzero, and every completion count matches the byte length of the DMA it closes. The rest can only be shown by the bench scenarios. These cover the sizing rules (wrap trimming, mask rounding, zero batches), the exact delays from request to DMA and from completion to strobe, a timer that keeps running when requests repeat, and the merge-or-drop decision for requests that arrive while a write is outstanding. Each scenario is scored against addresses, lengths and counts that the bench computes from the ring state it models.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ISSUE,
    ST_DMA,
    ST_DONE,
    ST_FINISH
  } wbc_state_e;
endpackage

// File: rtl/wbc_delay_timer.sv
module wbc_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/wbc_count_calc.sv
module wbc_count_calc #(
  parameter int IDX_W = 8,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [CNT_W-1:0] ring_len_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] room;
  logic [CNT_W-1:0] aligned;

  assign sum     = {2'b00, head_i} + {1'b0, used_i};
  assign wrap_o  = (sum >= {1'b0, ring_len_i});
  assign room    = ring_len_i - {1'b0, head_i};
  // zero mask leaves used_i unchanged
  assign aligned = used_i & ~{1'b0, mask_i};
  assign count_o = wrap_o ? room : aligned;
endmodule

// File: rtl/wbc_addr_gen.sv
module wbc_addr_gen #(
  parameter int IDX_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  localparam int CNT_W = IDX_W + 1,
  localparam int LEN_W = CNT_W + $clog2(DESC_BYTES)
) (
  input  logic [IDX_W-1:0]  head_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int SH   = $clog2(DESC_BYTES);
  localparam bit POW2 = ((1 << SH) == DESC_BYTES);

  logic [ADDR_W-1:0] offset;

  generate
    if (POW2) begin : g_shift
      assign offset = ADDR_W'(head_i) << SH;
      assign len_o  = LEN_W'(count_i) << SH;
    end else begin : g_mult
      assign offset = ADDR_W'(head_i) * ADDR_W'(DESC_BYTES);
      assign len_o  = LEN_W'(count_i) * LEN_W'(DESC_BYTES);
    end
  endgenerate

  assign addr_o = base_i + offset;
endmodule

// File: rtl/wb_coalesce_ctrl.sv
module wb_coalesce_ctrl
  import wbc_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  parameter int DLY_W      = 8,
  localparam int CNT_W = IDX_W + 1,
  localparam int LEN_W = CNT_W + $clog2(DESC_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_req_i,
  input  logic [IDX_W-1:0]  wb_mask_i,
  input  logic [DLY_W-1:0]  start_dly_i,
  input  logic [DLY_W-1:0]  done_dly_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic [CNT_W-1:0]  ring_len_i,
  input  logic [CNT_W-1:0]  used_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              dma_req_o,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic [LEN_W-1:0]  dma_len_o,
  input  logic              dma_done_i,
  output logic              wb_valid_o,
  output logic [CNT_W-1:0]  wb_count_o
);
  wbc_state_e        state_q, state_d;
  logic [IDX_W-1:0]  mask_q;
  logic              pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;

  logic              tmr_load;
  logic [DLY_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic [CNT_W-1:0]  calc_cnt;
  logic              calc_wrap;
  logic [ADDR_W-1:0] gen_addr;
  logic [LEN_W-1:0]  gen_len;
  logic              in_flight;
  logic              sizing;

  wbc_delay_timer #(.W(DLY_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_expired)
  );

  wbc_count_calc #(.IDX_W(IDX_W)) u_calc (
    .head_i     (head_i),
    .ring_len_i (ring_len_i),
    .used_i     (used_i),
    .mask_i     (mask_q),
    .count_o    (calc_cnt),
    .wrap_o     (calc_wrap)
  );

  wbc_addr_gen #(
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W),
    .DESC_BYTES (DESC_BYTES)
  ) u_addr (
    .head_i  (head_i),
    .count_i (calc_cnt),
    .base_i  (base_i),
    .addr_o  (gen_addr),
    .len_o   (gen_len)
  );

  assign in_flight = (state_q == ST_ISSUE) || (state_q == ST_DMA) || (state_q == ST_DONE);
  assign sizing    = (state_q == ST_START) && tmr_expired;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = start_dly_i;
    unique case (state_q)
      ST_IDLE: if (wb_req_i) begin
        state_d  = ST_START;
        tmr_load = 1'b1;
      end
      ST_START: if (tmr_expired) state_d = (calc_cnt == '0) ? ST_IDLE : ST_ISSUE;
      ST_ISSUE: state_d = ST_DMA;
      ST_DMA: if (dma_done_i) begin
        state_d  = ST_DONE;
        tmr_load = 1'b1;
        tmr_val  = done_dly_i;
      end
      ST_DONE: if (tmr_expired) state_d = ST_FINISH;
      ST_FINISH: begin
        if (pend_q || wb_req_i) begin
          state_d  = ST_START;
          tmr_load = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      if (wb_req_i) begin
        if (in_flight) begin
          // merge: keep the less restrictive mask, schedule a follow-up
          if (wb_mask_i < mask_q) begin
            mask_q <= wb_mask_i;
            pend_q <= 1'b1;
          end
        end else if (state_q == ST_FINISH && pend_q) begin
          if (wb_mask_i < mask_q) mask_q <= wb_mask_i;
        end else begin
          mask_q <= wb_mask_i;
        end
      end
      if (sizing) begin
        cnt_q  <= calc_cnt;
        addr_q <= gen_addr;
        len_q  <= gen_len;
        if (calc_wrap && calc_cnt != '0) pend_q <= 1'b1;
      end
      if (state_q == ST_FINISH) pend_q <= 1'b0;
    end
  end

  assign dma_req_o  = (state_q == ST_ISSUE);
  assign dma_addr_o = addr_q;
  assign dma_len_o  = len_q;
  assign wb_valid_o = (state_q == ST_FINISH);
  assign wb_count_o = cnt_q;
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int CNT_W      = 9,
  parameter int LEN_W      = 13,
  parameter int DESC_BYTES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dma_req_o,
  input logic [LEN_W-1:0] dma_len_o,
  input logic             wb_valid_o,
  input logic [CNT_W-1:0] wb_count_o
);
  logic             out_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] exp_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      len_q <= '0;
    end else begin
      if (dma_req_o) begin
        out_q <= 1'b1;
        len_q <= dma_len_o;
      end else if (wb_valid_o) begin
        out_q <= 1'b0;
      end
    end
  end

  assign exp_len = LEN_W'(wb_count_o) * LEN_W'(DESC_BYTES);

  assert_dma_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> !dma_req_o);

  assert_single_outstanding_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> !out_q);

  assert_len_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (dma_len_o != '0));

  assert_valid_needs_dma_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> out_q);

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o);

  assert_count_matches_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (exp_len == len_q));
endmodule

bind wb_coalesce_ctrl wbc_checker #(
  .CNT_W      (CNT_W),
  .LEN_W      (LEN_W),
  .DESC_BYTES (DESC_BYTES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dma_req_o  (dma_req_o),
  .dma_len_o  (dma_len_o),
  .wb_valid_o (wb_valid_o),
  .wb_count_o (wb_count_o)
);

// File: tb/wb_coalesce_ctrl_tb.sv
`timescale 1ns/1ps
module wb_coalesce_ctrl_tb;
  localparam int IDX_W = 8, ADDR_W = 32, DESC_BYTES = 16, DLY_W = 8;
  localparam int CNT_W = IDX_W + 1, LEN_W = CNT_W + 4;
  localparam int RING = 64;
  localparam logic [ADDR_W-1:0] BASE = 32'h1000_0000;

  typedef struct { longint addr; longint len; string tag; } dma_item_t;
  typedef struct { int cnt; string tag; } wb_item_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic              wb_req_i = 1'b0;
  logic [IDX_W-1:0]  wb_mask_i = '0;
  logic [DLY_W-1:0]  start_dly_i = '0, done_dly_i = '0;
  logic [IDX_W-1:0]  head_i;
  logic [CNT_W-1:0]  ring_len_i, used_i;
  logic [ADDR_W-1:0] base_i;
  logic              dma_req_o, dma_done_i = 1'b0, wb_valid_o;
  logic [ADDR_W-1:0] dma_addr_o;
  logic [LEN_W-1:0]  dma_len_o;
  logic [CNT_W-1:0]  wb_count_o;

  int head_r = 0, used_r = 0;
  assign head_i     = head_r[IDX_W-1:0];
  assign used_i     = used_r[CNT_W-1:0];
  assign ring_len_i = CNT_W'(RING);
  assign base_i     = BASE;

  wb_coalesce_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES), .DLY_W(DLY_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wb_req_i(wb_req_i), .wb_mask_i(wb_mask_i),
    .start_dly_i(start_dly_i), .done_dly_i(done_dly_i), .head_i(head_i),
    .ring_len_i(ring_len_i), .used_i(used_i), .base_i(base_i),
    .dma_req_o(dma_req_o), .dma_addr_o(dma_addr_o), .dma_len_o(dma_len_o),
    .dma_done_i(dma_done_i), .wb_valid_o(wb_valid_o), .wb_count_o(wb_count_o)
  );

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int dma_cnt = 0, wb_cnt = 0, wb_target = 0;
  int last_dma_cyc = 0, last_wb_cyc = 0, done_cyc = 0, req_cyc = 0;
  int done_cd = 0, dma_lat = 3;
  dma_item_t exp_dma[$];
  wb_item_t  exp_wb[$];
  dma_item_t di;
  wb_item_t  wi;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_cnt(input int h, input int u, input int m);
    if (h + u >= RING) return RING - h;
    return u & ~m;
  endfunction

  task automatic push(input int h, input int u, input int m, input string tag);
    int c;
    c = ref_cnt(h, u, m);
    if (c > 0) begin
      exp_dma.push_back('{addr: longint'(BASE) + h * DESC_BYTES, len: c * DESC_BYTES, tag: tag});
      exp_wb.push_back('{cnt: c, tag: tag});
      wb_target++;
    end
  endtask

  task automatic req(input int m);
    @(negedge clk_i);
    wb_req_i  = 1'b1;
    wb_mask_i = m[IDX_W-1:0];
    @(negedge clk_i);
    wb_req_i = 1'b0;
    req_cyc  = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_wb();
    while (wb_cnt < wb_target) @(negedge clk_i);
    idle(2);
  endtask

  // monitor, DMA responder and host model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (dma_done_i) dma_done_i = 1'b0;
      else if (done_cd > 0) begin
        done_cd--;
        if (done_cd == 0) begin
          dma_done_i = 1'b1;
          done_cyc   = cyc + 1;
        end
      end
      if (dma_req_o) begin
        dma_cnt++;
        last_dma_cyc = cyc;
        done_cd      = dma_lat;
        if (exp_dma.size() == 0) chk(1'b0, "R11 unexpected dma request", dma_addr_o, 0);
        else begin
          di = exp_dma.pop_front();
          chk(dma_addr_o == di.addr, {di.tag, " R6 dma address"}, dma_addr_o, di.addr);
          chk(dma_len_o == di.len, {di.tag, " R6 dma length"}, dma_len_o, di.len);
        end
      end
      if (wb_valid_o) begin
        wb_cnt++;
        last_wb_cyc = cyc;
        if (exp_wb.size() == 0) chk(1'b0, "R7 unexpected writeback strobe", wb_count_o, 0);
        else begin
          wi = exp_wb.pop_front();
          chk(wb_count_o == wi.cnt, {wi.tag, " R7 written-back count"}, wb_count_o, wi.cnt);
        end
        head_r = (head_r + int'(wb_count_o)) % RING;
        used_r = used_r - int'(wb_count_o);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog: actual %0d writebacks expected %0d", wb_cnt, wb_target);
    summary();
    $finish;
  end

  initial begin
    int d0, w0, c0;
    idle(3);
    chk(dma_req_o == 1'b0, "R1 dma_req_o in reset", dma_req_o, 0);
    chk(wb_valid_o == 1'b0, "R1 wb_valid_o in reset", wb_valid_o, 0);
    rst_ni = 1'b1;
    idle(3);
    chk(dma_req_o == 1'b0 && wb_valid_o == 1'b0, "R1 idle after reset", dma_req_o, 0);

    // R3 basic batch with start/completion latency
    start_dly_i = 8'd3; done_dly_i = 8'd2; dma_lat = 3;
    head_r = 0; used_r = 10;
    push(0, 10, 0, "R3");
    req(0);
    wait_wb();
    chk(last_dma_cyc - req_cyc == 4, "R2 start delay", last_dma_cyc - req_cyc, 4);
    chk(last_wb_cyc - done_cyc == 3, "R7 completion delay", last_wb_cyc - done_cyc, 3);

    // R5 mask rounding: 13 & ~3 = 12
    used_r = 13;
    push(10, 13, 3, "R5");
    req(3);
    wait_wb();

    // R10 zero count: 1 & ~3 = 0
    used_r = 1;
    d0 = dma_cnt; w0 = wb_cnt;
    req(3);
    idle(20);
    chk(dma_cnt == d0, "R10 no dma for zero count", dma_cnt, d0);
    chk(wb_cnt == w0, "R10 no strobe for zero count", wb_cnt, w0);

    // R4 wrap trim (61+9>=64 -> 3, mask ignored), then follow-up 6 & ~1 = 6
    head_r = 61; used_r = 9;
    push(61, 9, 1, "R4 wrap");
    push(0, 6, 1, "R4 follow-up");
    req(1);
    wait_wb();
    chk(head_r == 6, "R4 head after chained writebacks", head_r, 6);

    // R8 merge: in-flight request with smaller mask chains a follow-up
    head_r = 0; used_r = 16; dma_lat = 4;
    push(0, 16, 7, "R8 first");
    push(16, 6, 3, "R8 merged follow-up");
    d0 = dma_cnt;
    req(7);
    while (dma_cnt == d0) @(negedge clk_i);
    used_r = 22;
    req(3);
    wait_wb();

    // R9 drop: in-flight request with larger mask is ignored
    used_r = 8;
    push(20, 8, 3, "R9");
    d0 = dma_cnt;
    req(3);
    while (dma_cnt == d0) @(negedge clk_i);
    req(7);
    wait_wb();
    idle(30);
    chk(dma_cnt == d0 + 1, "R9 no follow-up dma", dma_cnt, d0 + 1);

    // R2 timer not restarted; second request overwrites mask (5 & ~0 = 5)
    start_dly_i = 8'd10;
    head_r = 4; used_r = 5;
    push(4, 5, 0, "R2 mask overwrite");
    req(7);
    c0 = req_cyc;
    idle(3);
    req(0);
    wait_wb();
    chk(last_dma_cyc - c0 == 11, "R2 timer not restarted", last_dma_cyc - c0, 11);

    // R2/R7 zero delays
    start_dly_i = 8'd0; done_dly_i = 8'd0; dma_lat = 1;
    head_r = 9; used_r = 20;
    push(9, 20, 0, "R3 zero delays");
    req(0);
    wait_wb();
    chk(last_dma_cyc - req_cyc == 1, "R2 zero start delay", last_dma_cyc - req_cyc, 1);
    chk(last_wb_cyc - done_cyc == 1, "R7 zero completion delay", last_wb_cyc - done_cyc, 1);

    idle(10);
    chk(exp_dma.size() == 0 && exp_wb.size() == 0, "R11 scoreboard drained",
        exp_dma.size() + exp_wb.size(), 0);
    summary();
    $finish;
  end
endmodule